// File: doc/BRIEF.md
# Prescaled 16x Baud Tick Generator

This block produces the oversampling clock enable that a serial transmitter and receiver share. It runs entirely on the reference clock. A coarse prescaler first thins the reference clock by one of four fixed factors. A 16-bit programmable down-counter then divides that enable stream further. The result is a single-cycle enable pulse, `tick_o`, that repeats at sixteen times the baud rate. Both directions of the serial link consume this one pulse, so they always run at the same speed.

Software loads the divisor one byte at a time, through separate low-byte and high-byte write strobes that share one data bus. A new divisor or prescale choice is taken up only when the running count wraps, so a reprogram mid-period never shortens a pulse interval. A divisor of zero parks the counter, and no pulses come out. After reset the divisor is zero, so the block stays silent until it is programmed.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor is 0 and the prescale select is taken as given by the `psel` input; with the divisor still 0 no `tick_o` pulse appears.
- R2: `tick_o` is high for exactly one reference-clock cycle. In steady state, consecutive rising edges of `tick_o` are exactly P*D cycles apart, where P is the prescale factor and D is the divisor.
- R3: The prescale factor P is chosen by `psel` as follows: 2'b00 gives 1, 2'b01 gives 3, 2'b10 gives 6 and 2'b11 gives 12.
- R4: A clock edge with `wr_lo` high loads `wdata` into divisor bits 7:0, and one with `wr_hi` high loads it into bits 15:8. Each strobe leaves the other byte unchanged.
- R5: With P=1 and D=1, `tick_o` is high on every cycle.
- R6: A divisor written during a period takes effect only at the end of that period. The interval in progress completes at the old length P*Dold, and the next interval is P*Dnew.
- R7: Writing a divisor of 0 during a period lets that period finish with one last pulse. After that pulse no further pulses appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psel | input | 2 | Prescale select (00:1, 01:3, 10:6, 11:12) |
| wdata | input | 8 | Divisor byte to be written |
| wr_lo | input | 1 | Write strobe for divisor bits 7:0 |
| wr_hi | input | 1 | Write strobe for divisor bits 15:8 |
| tick_o | output | 1 | One-cycle 16x baud enable |

## Verification
The bench targets the following corner cases.
- **Divide-by-one in both stages.** A counter that mishandles this case shows gaps instead of a continuous high enable.
- **Divisor rewrite just after a pulse.** An eager reload would give a short runt interval instead of finishing at the old length.
- **Divisor rewritten to zero.** A faulty design either keeps pulsing or drops the pending final pulse.
- **Byte strobes.** Writing only the high byte, then only the low byte, exposes any strobe that clobbers its neighbour.
- **Random sweep.** Random prescale and divisor pairs check the P*D interval. A swapped prescale decode or an off-by-one reload value shows up as a wrong interval.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DIV_W = 16;
  localparam int unsigned PRE_W = 4;
  localparam int unsigned SEL_W = 2;

  typedef logic [DIV_W-1:0] div_t;
  typedef logic [PRE_W-1:0] pre_t;

  function automatic pre_t pre_factor(input logic [SEL_W-1:0] sel);
    case (sel)
      2'b00:   return pre_t'(1);
      2'b01:   return pre_t'(3);
      2'b10:   return pre_t'(6);
      default: return pre_t'(12);
    endcase
  endfunction
endpackage

// File: rtl/baud_rst_sync.sv
module baud_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] psel,
  output logic             pre_en
);
  pre_t cnt_q, cnt_d;

  assign pre_en = (cnt_q == '0);

  // The factor is sampled only at reload, so a select change never cuts a slot short.
  always_comb begin
    if (pre_en) cnt_d = pre_factor(psel) - pre_t'(1);
    else        cnt_d = cnt_q - pre_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the count stays inside the largest factor
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= pre_t'(11));

  // R2: between enables the counter steps down by one
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |=> cnt_q == $past(cnt_q) - pre_t'(1));
endmodule

// File: rtl/baud_divider.sv
module baud_divider
  import baud_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pre_en,
  input  logic [7:0] wdata,
  input  logic       wr_lo,
  input  logic       wr_hi,
  output logic       tick_o
);
  div_t div_q, div_d;
  div_t cnt_q, cnt_d;
  logic tick_q, tick_d;

  // Divisor register: byte-wise write enables
  always_comb begin
    div_d = div_q;
    if (wr_lo) div_d[7:0]  = wdata;
    if (wr_hi) div_d[15:8] = wdata;
  end

  // Down-counter: reload from the divisor at wrap, idle while it holds zero
  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (pre_en) begin
      if (cnt_q == '0) begin
        cnt_d = div_q;
      end else if (cnt_q == div_t'(1)) begin
        cnt_d  = div_q;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - div_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= div_d;
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R7: a parked counter with a zero divisor produces nothing
  p_zero_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && div_q == '0) |=> !tick_o);

  // R2: every pulse follows a prescaler enable
  p_tick_on_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(pre_en));

  // R6: mid-period counts only step down, never jump to a new divisor
  p_no_runt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && cnt_q > div_t'(1)) |=> cnt_q == $past(cnt_q) - div_t'(1));

  // R4: a high-byte write alone keeps the low byte
  p_lo_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> div_q[7:0] == $past(div_q[7:0]));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] psel,
  input  logic [7:0]       wdata,
  input  logic             wr_lo,
  input  logic             wr_hi,
  output logic             tick_o
);
  logic rst_n_int;
  logic pre_en;

  baud_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  baud_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .psel   (psel),
    .pre_en (pre_en)
  );

  baud_divider u_div (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .pre_en (pre_en),
    .wdata  (wdata),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .tick_o (tick_o)
  );
endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] psel;
  logic [7:0] wdata;
  logic       wr_lo, wr_hi;
  logic       tick_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int prev_tick = 0;
  logic done = 1'b0;

  baud_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .wdata(wdata),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .tick_o(tick_o)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_factor(input logic [1:0] s);
    case (s)
      2'b00:   return 1;
      2'b01:   return 3;
      2'b10:   return 6;
      default: return 12;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_div(input int d);
    @(negedge clk); wdata = d[7:0];  wr_lo = 1'b1;
    @(negedge clk); wr_lo = 1'b0; wdata = d[15:8]; wr_hi = 1'b1;
    @(negedge clk); wr_hi = 1'b0;
  endtask

  // Wait for the next pulse; returns the interval since the last one, -1 on timeout
  task automatic wait_tick(input int limit, output int interval);
    interval = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (tick_o) begin
        interval  = cyc - prev_tick;
        prev_tick = cyc;
        return;
      end
    end
  endtask

  task automatic settle(input int limit);
    int dummy;
    wait_tick(limit, dummy);
    wait_tick(limit, dummy);
    wait_tick(limit, dummy);
  endtask

  task automatic count_ticks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tick_o) cnt++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int iv, n, d, s, seed;
    seed  = $urandom(32'd1234);
    rst_n = 1'b0; psel = 2'b00; wdata = '0; wr_lo = 1'b0; wr_hi = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: silent after reset with divisor 0
    check("R1 tick at reset", int'(tick_o), 0);
    count_ticks(200, n);
    check("R1 ticks before programming", n, 0);

    // R5: P=1, D=1 gives a continuous enable
    write_div(1);
    settle(50);
    for (int k = 0; k < 4; k++) begin
      wait_tick(50, iv);
      check("R5 interval with P=1 D=1", iv, 1);
    end

    // R2 / R3: each prescale code with a fixed divisor
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); psel = k[1:0];
      write_div(5);
      settle(400);
      wait_tick(400, iv);
      check("R3 prescale code interval", iv, exp_factor(k[1:0]) * 5);
      count_ticks(1, n);
      check("R2 pulse width one cycle", n, 0);
    end

    // R2 / R3: random prescale and divisor pairs
    for (int k = 0; k < 10; k++) begin
      s = int'($urandom % 4);
      d = 1 + int'($urandom % 100);
      @(negedge clk); psel = s[1:0];
      write_div(d);
      settle(5000);
      wait_tick(5000, iv);
      check("R2 random interval", iv, exp_factor(s[1:0]) * d);
      wait_tick(5000, iv);
      check("R2 random interval repeat", iv, exp_factor(s[1:0]) * d);
    end

    // R4: high byte alone, then low byte alone
    @(negedge clk); psel = 2'b00;
    write_div(7);
    settle(2000);
    @(negedge clk); wdata = 8'h01; wr_hi = 1'b1;
    @(negedge clk); wr_hi = 1'b0;
    settle(2000);
    wait_tick(2000, iv);
    check("R4 high byte only (263)", iv, 263);
    @(negedge clk); wdata = 8'h02; wr_lo = 1'b1;
    @(negedge clk); wr_lo = 1'b0;
    settle(2000);
    wait_tick(2000, iv);
    check("R4 low byte only (258)", iv, 258);

    // R6: rewrite right after a pulse completes the old period first
    @(negedge clk); psel = 2'b01;
    write_div(20);
    settle(2000);
    wait_tick(2000, iv);
    write_div(7);
    wait_tick(2000, iv);
    check("R6 period in progress keeps old length", iv, 60);
    wait_tick(2000, iv);
    check("R6 next period uses new divisor", iv, 21);

    // R7: divisor 0 lets the current period end, then stops
    @(negedge clk); psel = 2'b00;
    write_div(10);
    settle(200);
    wait_tick(200, iv);
    write_div(0);
    wait_tick(200, iv);
    check("R7 final pulse interval", iv, 10);
    count_ticks(300, n);
    check("R7 no pulses after stop", n, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule